// File: doc/BRIEF.md
# Embedded Timing Reference and Sync Pulse Generator

This block produces the raster timing for a 10-bit, 4:2:2 interleaved video word stream (chroma and luma words alternate, starting with a chroma word). Each line ends with an end-of-active-video code and each active region starts with a start-of-active-video code. Both codes are four words long: a 0x3FF preamble word, two 0x000 words, and a flag word. The flag word carries the field, vertical-blank and horizontal-position bits, protected by four parity bits. Between the codes, the block emits the blanking levels or passes through pixel words taken from a plain input bus.

A selector chooses between a 525-line and a 625-line raster. Three 5-bit line offsets place three vertical events: the rise of the vertical-blank flag, its fall, and the change of the field flag. Each event can be pushed back one extra line, separately in the first field and in the second. Every vertical setting moves the flag bits inside the codes and the VS and FIELD pins in the same way. The HS pin is a window on the horizontal word counter. Its two 11-bit edge positions are counted from the cycle just after the end-of-line flag word. An optional mode forces the chroma words of vertical-blank lines to the chroma blank level and leaves luma untouched.

Top module: `sav_eav_sync_gen`

## Requirements
- R1: While `rst_n` is low, `data_o` is 0 and `hs_o`, `vs_o` and `field_o` are 0. After release, the first output word is horizontal count 0 of line 1.
- R2: The horizontal count runs from 0 to L-1, where L is `LEN_A` (525-line raster) or `LEN_B` (625-line raster), and B = L - `ACT` - 8. Counts 0 to B-1 carry blanking words: 0x200 at even counts, 0x040 at odd counts. Counts B to B+3 carry the start code, counts L-4 to L-1 carry the end code, and each code is 0x3FF, 0x000, 0x000, then a flag word.
- R3: The flag word is, from bit 9 down to bit 0: 1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0. H is 0 in the start code and 1 in the end code.
- R4: Lines count from 1 to 525 when `std_sel_i` = 0 and from 1 to 625 when it is 1. The line number steps once per line, when the horizontal count returns to 0 after L-1.
- R5: Let P = (N+1)/2, where N is the line total, and let G be `VB_A` or `VB_B` according to the raster. V is 1 on lines 1+`vbeg_i` up to, but not including, 1+G+`vend_i`. V is also 1 on lines P+`vbeg_i` up to, but not including, P+G+`vend_i`.
- R6: F is 1 from line P+`ftog_i` to the last line, and on lines below 1+`ftog_i`. F is 0 on all other lines.
- R7: In each delay input, bit 0 applies to the first-field event (based on line 1) and bit 1 to the second-field event (based on line P). A set bit adds one line to that event. The delay inputs are `vbeg_dly_i`, `vend_dly_i` and `ftog_dly_i`.
- R8: `vs_o` and `field_o` equal the V and F flags of the line whose word is on `data_o` in the same cycle, so they match bits 7 and 8 of every flag word.
- R9: `hs_o` is 1 for a word at count c when c is in the half-open window from `hs_begin_i` to `hs_end_i`. If begin is greater than end, the window wraps past the end of the line. If begin equals end, `hs_o` stays 0.
- R10: With `cblank_i` = 1, on a line where V = 1, the active words at even distance from the start code's last word + 1 (the chroma words) are 0x200. The luma words still carry the pixel input.
- R11: Every active word not forced by R10 equals the `pix_i` value presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_sel_i | input | 1 | Raster select: 0 = 525 lines, 1 = 625 lines |
| hs_begin_i | input | 11 | Horizontal count at which HS rises |
| hs_end_i | input | 11 | Horizontal count at which HS falls |
| vbeg_i | input | 5 | Line offset of the V rise |
| vend_i | input | 5 | Line offset of the V fall, added to the blank length |
| ftog_i | input | 5 | Line offset of the field change |
| vbeg_dly_i | input | 2 | Extra-line delay of the V rise: bit 0 first field, bit 1 second field |
| vend_dly_i | input | 2 | Extra-line delay of the V fall, same bit use |
| ftog_dly_i | input | 2 | Extra-line delay of the field change, same bit use |
| cblank_i | input | 1 | Force chroma to blank on vertical-blank lines |
| pix_i | input | 10 | Pixel word for the active region |
| data_o | output | 10 | Interleaved output word stream with timing codes |
| hs_o | output | 1 | Horizontal sync pin |
| vs_o | output | 1 | Vertical sync pin |
| field_o | output | 1 | Field pin |

## Verification
The stream is driven through four configurations, each over a whole frame:
- The 525-line raster with default offsets and a plain HS window. This separates the basic code placement from everything else.
- The 625-line raster with mixed per-field delays, chroma blanking and a wrapped HS window. This shows whether the first-field and second-field delay bits are routed to the right events.
- The 525-line raster with a zero V rise offset, equal HS edges and second-field delays. This probes the empty-window and line-1 corner.
- The 625-line raster with every offset at its maximum and a one-word HS pulse at the last count. This exposes truncated arithmetic.

A pseudo-random pixel stream distinguishes passed-through luma from forced chroma. The spacing of VS rises shows whether the line total and field base follow the raster select.

// File: rtl/sesg_pkg.sv
package sesg_pkg;

  localparam int WORD_W = 10;

  localparam logic [WORD_W-1:0] W_PRE  = 10'h3FF;
  localparam logic [WORD_W-1:0] W_ZERO = 10'h000;
  localparam logic [WORD_W-1:0] W_CBLK = 10'h200;
  localparam logic [WORD_W-1:0] W_YBLK = 10'h040;

  typedef enum logic [1:0] {
    SEG_BLANK = 2'd0,
    SEG_SAV   = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_EAV   = 2'd3
  } seg_e;

  // Flag word of a timing code: fixed 1, F, V, H, four protection bits, two zero LSBs
  function automatic logic [WORD_W-1:0] xy_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  // Half-open window on a cyclic count; wraps when begin > end, empty when equal
  function automatic logic in_hwin(input logic [15:0] pos, input logic [15:0] b,
                                   input logic [15:0] e);
    if (b < e)      return (pos >= b) && (pos < e);
    else if (b > e) return (pos >= b) || (pos < e);
    else            return 1'b0;
  endfunction

  // Half-open line span
  function automatic logic in_span(input logic [15:0] pos, input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (pos >= lo) && (pos < hi);
  endfunction

endpackage

// File: rtl/sesg_raster.sv
module sesg_raster #(
  parameter int LEN_A   = 1716,
  parameter int LEN_B   = 1728,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int HW      = 11,
  parameter int LW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_i,
  output logic [HW-1:0] hcnt,
  output logic [LW-1:0] line,
  output logic          line_wrap
);

  localparam logic [HW-1:0] LAST_A = HW'(LEN_A - 1);
  localparam logic [HW-1:0] LAST_B = HW'(LEN_B - 1);
  localparam logic [LW-1:0] NL_A   = LW'(LINES_A);
  localparam logic [LW-1:0] NL_B   = LW'(LINES_B);

  logic [HW-1:0] last;
  logic [LW-1:0] nlines;

  assign last      = std_i ? LAST_B : LAST_A;
  assign nlines    = std_i ? NL_B : NL_A;
  assign line_wrap = (hcnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      line <= LW'(1);
    end else if (line_wrap) begin
      hcnt <= '0;
      line <= (line >= nlines) ? LW'(1) : line + LW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

endmodule

// File: rtl/sesg_vtiming.sv
module sesg_vtiming
  import sesg_pkg::*;
#(
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int VB_A    = 16,
  parameter int VB_B    = 20,
  parameter int LW      = 10,
  parameter int VW      = 5
) (
  input  logic          std_i,
  input  logic [LW-1:0] line,
  input  logic [VW-1:0] vbeg_i,
  input  logic [VW-1:0] vend_i,
  input  logic [VW-1:0] ftog_i,
  input  logic [1:0]    vbeg_dly_i,
  input  logic [1:0]    vend_dly_i,
  input  logic [1:0]    ftog_dly_i,
  output logic          v_flag,
  output logic          f_flag
);

  localparam logic [15:0] BASE2_A = 16'((LINES_A + 1) / 2);
  localparam logic [15:0] BASE2_B = 16'((LINES_B + 1) / 2);
  localparam logic [15:0] GAP_A   = 16'(VB_A);
  localparam logic [15:0] GAP_B   = 16'(VB_B);

  logic [15:0] l16, base2, gap;
  logic [15:0] v1b, v1e, v2b, v2e, t1, t2;

  always_comb begin
    l16   = 16'(line);
    base2 = std_i ? BASE2_B : BASE2_A;
    gap   = std_i ? GAP_B : GAP_A;
    v1b   = 16'd1 + 16'(vbeg_i) + 16'(vbeg_dly_i[0]);
    v2b   = base2 + 16'(vbeg_i) + 16'(vbeg_dly_i[1]);
    v1e   = 16'd1 + gap + 16'(vend_i) + 16'(vend_dly_i[0]);
    v2e   = base2 + gap + 16'(vend_i) + 16'(vend_dly_i[1]);
    t1    = 16'd1 + 16'(ftog_i) + 16'(ftog_dly_i[0]);
    t2    = base2 + 16'(ftog_i) + 16'(ftog_dly_i[1]);
  end

  assign v_flag = in_span(l16, v1b, v1e) | in_span(l16, v2b, v2e);
  assign f_flag = (l16 >= t2) | (l16 < t1);

endmodule

// File: rtl/sesg_formatter.sv
module sesg_formatter
  import sesg_pkg::*;
#(
  parameter int LEN_A = 1716,
  parameter int LEN_B = 1728,
  parameter int ACT   = 1440,
  parameter int HW    = 11,
  parameter int HPW   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_i,
  input  logic [HW-1:0]     hcnt,
  input  logic              v_flag,
  input  logic              f_flag,
  input  logic [WORD_W-1:0] pix_i,
  input  logic              cblank_i,
  input  logic [HPW-1:0]    hs_begin_i,
  input  logic [HPW-1:0]    hs_end_i,
  output logic [WORD_W-1:0] data_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic              field_o,
  output logic              xy_q,
  output logic              cbl_q
);

  localparam logic [15:0] L_A   = 16'(LEN_A);
  localparam logic [15:0] L_B   = 16'(LEN_B);
  localparam logic [15:0] BLK_A = 16'(LEN_A - ACT - 8);
  localparam logic [15:0] BLK_B = 16'(LEN_B - ACT - 8);

  logic [15:0]       h16, len16, blk16;
  seg_e              seg;
  logic [1:0]        k;
  logic              chroma_pos, cbl_slot, xy_slot, hs_n;
  logic [WORD_W-1:0] word;

  always_comb begin
    h16   = 16'(hcnt);
    len16 = std_i ? L_B : L_A;
    blk16 = std_i ? BLK_B : BLK_A;

    if (h16 < blk16)               seg = SEG_BLANK;
    else if (h16 < blk16 + 16'd4)  seg = SEG_SAV;
    else if (h16 < len16 - 16'd4)  seg = SEG_ACT;
    else                           seg = SEG_EAV;

    // position inside a four-word code (start and end both aligned mod 4)
    k = (seg == SEG_SAV) ? (h16[1:0] - blk16[1:0]) : (h16[1:0] - len16[1:0]);

    // active word index parity: offset from blk+4 is even for chroma
    chroma_pos = ~(h16[0] ^ blk16[0]);
    cbl_slot   = (seg == SEG_ACT) && cblank_i && v_flag && chroma_pos;
    xy_slot    = ((seg == SEG_SAV) || (seg == SEG_EAV)) && (k == 2'd3);

    unique case (seg)
      SEG_BLANK: word = h16[0] ? W_YBLK : W_CBLK;
      SEG_ACT:   word = cbl_slot ? W_CBLK : pix_i;
      default: begin
        if (k == 2'd0)      word = W_PRE;
        else if (k == 2'd3) word = xy_word(f_flag, v_flag, seg == SEG_EAV);
        else                word = W_ZERO;
      end
    endcase

    hs_n = in_hwin(h16, 16'(hs_begin_i), 16'(hs_end_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      hs_o    <= 1'b0;
      vs_o    <= 1'b0;
      field_o <= 1'b0;
      xy_q    <= 1'b0;
      cbl_q   <= 1'b0;
    end else begin
      data_o  <= word;
      hs_o    <= hs_n;
      vs_o    <= v_flag;
      field_o <= f_flag;
      xy_q    <= xy_slot;
      cbl_q   <= cbl_slot;
    end
  end

endmodule

// File: rtl/sav_eav_sync_gen.sv
module sav_eav_sync_gen #(
  parameter int LEN_A   = 1716,
  parameter int LEN_B   = 1728,
  parameter int ACT     = 1440,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int VB_A    = 16,
  parameter int VB_B    = 20,
  parameter int HPW     = 11,
  parameter int VW      = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           std_sel_i,
  input  logic [HPW-1:0] hs_begin_i,
  input  logic [HPW-1:0] hs_end_i,
  input  logic [VW-1:0]  vbeg_i,
  input  logic [VW-1:0]  vend_i,
  input  logic [VW-1:0]  ftog_i,
  input  logic [1:0]     vbeg_dly_i,
  input  logic [1:0]     vend_dly_i,
  input  logic [1:0]     ftog_dly_i,
  input  logic           cblank_i,
  input  logic [9:0]     pix_i,
  output logic [9:0]     data_o,
  output logic           hs_o,
  output logic           vs_o,
  output logic           field_o
);

  localparam int LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int HW      = $clog2(LEN_MAX);
  localparam int LW      = $clog2(((LINES_A > LINES_B) ? LINES_A : LINES_B) + 1);

  logic [HW-1:0] hcnt_w;
  logic [LW-1:0] line_w;
  logic          line_wrap_w, v_w, f_w, xy_q_w, cbl_q_w;

  sesg_raster #(
    .LEN_A(LEN_A), .LEN_B(LEN_B), .LINES_A(LINES_A), .LINES_B(LINES_B), .HW(HW), .LW(LW)
  ) u_raster (
    .clk(clk), .rst_n(rst_n), .std_i(std_sel_i),
    .hcnt(hcnt_w), .line(line_w), .line_wrap(line_wrap_w)
  );

  sesg_vtiming #(
    .LINES_A(LINES_A), .LINES_B(LINES_B), .VB_A(VB_A), .VB_B(VB_B), .LW(LW), .VW(VW)
  ) u_vtiming (
    .std_i(std_sel_i), .line(line_w),
    .vbeg_i(vbeg_i), .vend_i(vend_i), .ftog_i(ftog_i),
    .vbeg_dly_i(vbeg_dly_i), .vend_dly_i(vend_dly_i), .ftog_dly_i(ftog_dly_i),
    .v_flag(v_w), .f_flag(f_w)
  );

  sesg_formatter #(
    .LEN_A(LEN_A), .LEN_B(LEN_B), .ACT(ACT), .HW(HW), .HPW(HPW)
  ) u_formatter (
    .clk(clk), .rst_n(rst_n), .std_i(std_sel_i), .hcnt(hcnt_w),
    .v_flag(v_w), .f_flag(f_w), .pix_i(pix_i), .cblank_i(cblank_i),
    .hs_begin_i(hs_begin_i), .hs_end_i(hs_end_i),
    .data_o(data_o), .hs_o(hs_o), .vs_o(vs_o), .field_o(field_o),
    .xy_q(xy_q_w), .cbl_q(cbl_q_w)
  );

endmodule

// File: rtl/sesg_chk.sv
module sesg_chk #(
  parameter int LEN_A   = 1716,
  parameter int LEN_B   = 1728,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int HW      = 11,
  parameter int LW      = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          std_sel_i,
  input logic [HW-1:0] hcnt,
  input logic [LW-1:0] line,
  input logic          line_wrap,
  input logic          xy_q,
  input logic          cbl_q,
  input logic [9:0]    data_o,
  input logic          vs_o,
  input logic          field_o
);

  logic [31:0] len_now, nl_now;
  assign len_now = std_sel_i ? 32'(LEN_B) : 32'(LEN_A);
  assign nl_now  = std_sel_i ? 32'(LINES_B) : 32'(LINES_A);

  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hcnt) < len_now); // R2

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (line >= LW'(1)) && (32'(line) <= nl_now)); // R4

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_wrap |=> $stable(line)); // R4

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wrap && (32'(line) < nl_now)) |=> (line == $past(line) + LW'(1))); // R4

  AST_XY_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    xy_q |-> (data_o[9] && (data_o[1:0] == 2'b00)
              && (data_o[5] == (data_o[7] ^ data_o[6]))
              && (data_o[4] == (data_o[8] ^ data_o[6]))
              && (data_o[3] == (data_o[8] ^ data_o[7]))
              && (data_o[2] == (data_o[8] ^ data_o[7] ^ data_o[6])))); // R3

  AST_XY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    xy_q |-> ((data_o[8] == field_o) && (data_o[7] == vs_o))); // R8

  AST_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    xy_q |-> (($past(data_o, 1) == 10'h000) && ($past(data_o, 2) == 10'h000)
              && ($past(data_o, 3) == 10'h3FF))); // R2

  AST_CHROMA_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    cbl_q |-> (vs_o && (data_o == 10'h200))); // R10

endmodule

bind sav_eav_sync_gen sesg_chk #(
  .LEN_A(LEN_A), .LEN_B(LEN_B), .LINES_A(LINES_A), .LINES_B(LINES_B), .HW(HW), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .std_sel_i(std_sel_i),
  .hcnt(hcnt_w), .line(line_w), .line_wrap(line_wrap_w),
  .xy_q(xy_q_w), .cbl_q(cbl_q_w),
  .data_o(data_o), .vs_o(vs_o), .field_o(field_o)
);

// File: tb/sav_eav_sync_gen_bench.sv
module sav_eav_sync_gen_bench;

  localparam int LEN_A = 40;
  localparam int LEN_B = 48;
  localparam int ACT   = 16;
  localparam int NLA   = 525;
  localparam int NLB   = 625;
  localparam int GAPA  = 16;
  localparam int GAPB  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        std_sel_i = 1'b0;
  logic [10:0] hs_begin_i = '0, hs_end_i = '0;
  logic [4:0]  vbeg_i = '0, vend_i = '0, ftog_i = '0;
  logic [1:0]  vbeg_dly_i = '0, vend_dly_i = '0, ftog_dly_i = '0;
  logic        cblank_i = 1'b0;
  logic [9:0]  pix_i = 10'h155;
  logic [9:0]  data_o;
  logic        hs_o, vs_o, field_o;

  always #5 clk = ~clk;

  sav_eav_sync_gen #(
    .LEN_A(LEN_A), .LEN_B(LEN_B), .ACT(ACT), .LINES_A(NLA), .LINES_B(NLB),
    .VB_A(GAPA), .VB_B(GAPB)
  ) u_sav_eav_sync_gen (
    .clk(clk), .rst_n(rst_n), .std_sel_i(std_sel_i),
    .hs_begin_i(hs_begin_i), .hs_end_i(hs_end_i),
    .vbeg_i(vbeg_i), .vend_i(vend_i), .ftog_i(ftog_i),
    .vbeg_dly_i(vbeg_dly_i), .vend_dly_i(vend_dly_i), .ftog_dly_i(ftog_dly_i),
    .cblank_i(cblank_i), .pix_i(pix_i),
    .data_o(data_o), .hs_o(hs_o), .vs_o(vs_o), .field_o(field_o)
  );

  int  checks = 0;
  int  errors = 0;
  bit  chk_en = 1'b0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // pseudo-random pixel words
  always @(negedge clk) pix_i <= {pix_i[8:0], pix_i[9] ^ pix_i[6]};

  // ---------------- behavioural reference ----------------
  int    mh = 0, ml = 1;
  int    e_data = 0;
  bit    e_hs = 0, e_vs = 0, e_f = 0, e_xy = 0;
  string e_tag = "R1";

  function automatic int mkxy(int f, int v, int h);
    return 512 + f*256 + v*128 + h*64 + (v^h)*32 + (f^h)*16 + (f^v)*8 + (f^v^h)*4;
  endfunction

  function automatic bit hwin(int p, int b, int e);
    if (b == e) return 0;
    if (b < e)  return (p >= b && p < e);
    return (p >= b || p < e);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; ml = 1;
      e_data = 0; e_hs = 0; e_vs = 0; e_f = 0; e_xy = 0; e_tag = "R1";
    end else begin
      int len, nl, blank, half, gap, v, f, k;
      len   = std_sel_i ? LEN_B : LEN_A;
      nl    = std_sel_i ? NLB : NLA;
      gap   = std_sel_i ? GAPB : GAPA;
      blank = len - ACT - 8;
      half  = (nl + 1) / 2;
      v = ((ml >= 1 + vbeg_i + vbeg_dly_i[0]) && (ml < 1 + gap + vend_i + vend_dly_i[0])) ||
          ((ml >= half + vbeg_i + vbeg_dly_i[1]) && (ml < half + gap + vend_i + vend_dly_i[1]));
      f = (ml >= half + ftog_i + ftog_dly_i[1]) || (ml < 1 + ftog_i + ftog_dly_i[0]);
      e_xy = 0;
      if (mh < blank) begin
        e_data = (mh % 2) ? 'h040 : 'h200; e_tag = "R2";
      end else if (mh < blank + 4 || mh >= len - 4) begin
        k = (mh < blank + 4) ? mh - blank : mh - (len - 4);
        e_tag = "R2";
        if (k == 0) e_data = 'h3FF;
        else if (k == 3) begin
          e_data = mkxy(f, v, (mh >= len - 4) ? 1 : 0); e_tag = "R3"; e_xy = 1;
        end else e_data = 0;
      end else if (cblank_i && v && ((mh - blank - 4) % 2 == 0)) begin
        e_data = 'h200; e_tag = "R10";
      end else begin
        e_data = int'(pix_i); e_tag = "R11";
      end
      e_hs = hwin(mh, hs_begin_i, hs_end_i);
      e_vs = v[0];
      e_f  = f[0];
      if (mh == len - 1) begin
        mh = 0;
        ml = (ml == nl) ? 1 : ml + 1;
      end else mh = mh + 1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      check(data_o == 10'(e_data), e_tag, int'(data_o), e_data);
      check(hs_o == e_hs, "R9 hs", int'(hs_o), int'(e_hs));
      check(vs_o == e_vs, (vbeg_dly_i != 0 || vend_dly_i != 0) ? "R7 vs" : "R5 vs",
            int'(vs_o), int'(e_vs));
      check(field_o == e_f, (ftog_dly_i != 0) ? "R7 field" : "R6 field",
            int'(field_o), int'(e_f));
      if (e_xy)
        check(data_o[7] == vs_o && data_o[8] == field_o, "R8 flag/pin",
              int'({data_o[8], data_o[7]}), int'({field_o, vs_o}));
    end
  end

  task automatic run(input bit s, input int hb, input int he, input int vb, input int ve,
                     input int ft, input logic [1:0] db, input logic [1:0] de,
                     input logic [1:0] df, input bit cb, input int cycles);
    int len, half, rises, first_rise, exp_gap;
    bit prev;
    @(negedge clk);
    chk_en = 0;
    rst_n = 0;
    std_sel_i = s; hs_begin_i = 11'(hb); hs_end_i = 11'(he);
    vbeg_i = 5'(vb); vend_i = 5'(ve); ftog_i = 5'(ft);
    vbeg_dly_i = db; vend_dly_i = de; ftog_dly_i = df; cblank_i = cb;
    repeat (3) @(negedge clk);
    // R1: all outputs quiet under reset
    check(data_o == 0 && !hs_o && !vs_o && !field_o, "R1 reset",
          int'({data_o, hs_o, vs_o, field_o}), 0);
    rst_n = 1;
    chk_en = 1;
    len  = s ? LEN_B : LEN_A;
    half = s ? (NLB + 1) / 2 : (NLA + 1) / 2;
    exp_gap = (half - 1 + int'(db[1]) - int'(db[0])) * len;
    rises = 0; first_rise = 0; prev = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (vs_o && !prev) begin
        if (rises == 0) first_rise = i;
        else if (rises == 1)
          // R4: spacing of the two VS rises follows line length and field base
          check(i - first_rise == exp_gap, "R4 line count", i - first_rise, exp_gap);
        rises++;
      end
      prev = vs_o;
    end
  endtask

  initial begin
    // 525 lines, default offsets, plain HS window
    run(1'b0, 4, 20, 5, 4, 3, 2'b00, 2'b00, 2'b00, 1'b0, NLA * LEN_A + 100);
    // 625 lines, defaults, mixed field delays, chroma blank, wrapped HS
    run(1'b1, 44, 6, 1, 4, 6, 2'b11, 2'b01, 2'b10, 1'b1, NLB * LEN_B + 100);
    // 525 lines, V rise on line 1, equal HS edges, second-field delays
    run(1'b0, 0, 0, 0, 7, 9, 2'b10, 2'b10, 2'b01, 1'b1, NLA * LEN_A + 100);
    // 625 lines, all offsets at maximum, one-word HS at the last count
    run(1'b1, LEN_B - 1, 0, 31, 31, 31, 2'b01, 2'b11, 2'b11, 1'b0, NLB * LEN_B + 100);
    chk_en = 0;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule